// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is the configuration entry point of a frequency synthesizer. An external controller drives three pins: a serial clock, a serial data line and a latch strobe. The controller sends a 22-bit word, most significant bit first, one bit per serial clock rising edge. It then raises the latch strobe. At that rise, the upper 20 bits of the word are written into one of four 20-bit control registers. The two bits sent last select which register is written. All four registers drive the rest of the synthesizer in parallel.

The three pins are sampled in the core clock domain through a short synchronizer chain. Edges are detected in that domain. When a register is written, a single-cycle one-hot strobe marks which one changed. Nothing in the block depends on any power state of the device, so the port can always be written.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each rising edge of `serClk`, the level on `serData` is shifted into a 22-bit frame register. The first bit sent ends up as frame bit 21, which is the MSB.
- R2: Frame bits [1:0], the last two bits sent, form a register index from 0 to 3. That index selects `ctrlRegs[index]`.
- R3: When a load occurs, the selected register receives frame bits [21:2]. Frame bit 21 lands in register bit 19.
- R4: A load happens only on a low-to-high transition of `serLatch`. Shifting with `serLatch` low changes no register. Holding `serLatch` high while more bits are shifted causes no further load.
- R5: The three registers not selected by a load keep their values.
- R6: When more than 22 bits are sent before the latch rise, only the last 22 bits count.
- R7: `update` is one-hot for exactly one core cycle, with bit k set when register k was loaded. The new value of that register is visible in the same cycle. At all other times `update` is zero.
- R8: While `rstN` is low, all four registers and `update` are zero.
- R9: A later load to the same index replaces that register's earlier value completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock; the rising edge samples data |
| serData | input | 1 | Serial data, MSB first |
| serLatch | input | 1 | Latch strobe; the rising edge transfers the frame |
| ctrlRegs | output | 4x20 | The four control registers, indexed by address |
| update | output | 4 | One-cycle one-hot strobe naming the register just written |

## Verification
Frames go to every index with payloads of distinct patterns: alternating bits, a single set MSB and all ones. These show whether the address decode and the payload bit order are right. A frame is then shifted and never latched, which shows whether a load can occur without a latch edge. A second frame shifted while the latch is held high, and loaded only by the next rise, separates edge-triggered from level-triggered transfer. A 27-bit burst whose leading bits are junk checks that only the newest 22 bits are kept.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  // Commands passed from control to datapath, one core cycle each
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic bitIn;
  } serCmd_t;
endpackage

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serLatch,
  output serCmd_t cmd
);
  // Pin order inside each stage: {latch, clock, data}
  localparam int PIN_N = 3;

  logic [SYNC_STAGES-1:0][PIN_N-1:0] syncPipe;
  logic [PIN_N-1:0] syncNow;
  logic [1:0] prevEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      prevEdge <= '0;
    end else begin
      syncPipe[0] <= {serLatch, serClk, serData};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      prevEdge <= syncPipe[SYNC_STAGES-1][2:1];
    end
  end

  assign syncNow = syncPipe[SYNC_STAGES-1];

  always_comb begin
    cmd.shiftEn = syncNow[1] & ~prevEdge[0];
    cmd.loadEn  = syncNow[2] & ~prevEdge[1];
    cmd.bitIn   = syncNow[0];
  end
endmodule

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_W = 22,
  parameter int ADDR_W  = 2,
  localparam int PAYLOAD_W = FRAME_W - ADDR_W,
  localparam int NUM_REGS  = 1 << ADDR_W
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  serCmd_t                            cmd,
  output logic [NUM_REGS-1:0][PAYLOAD_W-1:0] ctrlRegs,
  output logic [NUM_REGS-1:0]                update
);
  logic [FRAME_W-1:0]   frameReg;
  logic [ADDR_W-1:0]    frameAddr;
  logic [PAYLOAD_W-1:0] framePayload;
  logic [NUM_REGS-1:0]  selectHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameReg <= '0;
    else if (cmd.shiftEn) frameReg <= {frameReg[FRAME_W-2:0], cmd.bitIn};
  end

  assign frameAddr    = frameReg[ADDR_W-1:0];
  assign framePayload = frameReg[FRAME_W-1:ADDR_W];

  always_comb begin
    selectHot = '0;
    selectHot[frameAddr] = cmd.loadEn;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctrlRegs[k] <= '0;
      else if (selectHot[k]) ctrlRegs[k] <= framePayload;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) update <= '0;
    else update <= selectHot;
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_W     = 22,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                                 clk,
  input  logic                                                 rstN,
  input  logic                                                 serClk,
  input  logic                                                 serData,
  input  logic                                                 serLatch,
  output logic [(1 << ADDR_W)-1:0][FRAME_W-ADDR_W-1:0]         ctrlRegs,
  output logic [(1 << ADDR_W)-1:0]                             update
);
  serCmd_t cmd;

  cfg_loader_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .cmd(cmd)
  );

  cfg_loader_dp #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .ctrlRegs(ctrlRegs), .update(update)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
  parameter int FRAME_W = 22,
  parameter int ADDR_W  = 2,
  localparam int PAYLOAD_W = FRAME_W - ADDR_W,
  localparam int NUM_REGS  = 1 << ADDR_W
) (
  input logic                               clk,
  input logic                               rstN,
  input logic [NUM_REGS-1:0][PAYLOAD_W-1:0] ctrlRegs,
  input logic [NUM_REGS-1:0]                update
);
  // R7: never more than one register flagged
  p_update_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(update));

  // R7: strobe lasts a single cycle
  p_update_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (update != '0) |=> (update == '0));

  // R8: reset state
  p_reset_zero_r8: assert property (@(posedge clk)
    !rstN |-> (ctrlRegs == '0 && update == '0));

  // R4: any register change is announced
  p_change_flagged_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlRegs) |-> (update != '0));

  // R5: a register not flagged keeps its value
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_hold
    p_unselected_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      !update[k] |-> $stable(ctrlRegs[k]));
  end
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .ctrlRegs(ctrlRegs), .update(update)
);

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLatch = 1'b0;
  logic [3:0][19:0] ctrlRegs;
  logic [3:0] update;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int qAddr[$];
  logic [19:0] qData[$];
  logic [3:0][19:0] model = '0;

  always #5 clk = ~clk;

  serial_cfg_loader i_serial_cfg_loader (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .ctrlRegs(ctrlRegs), .update(update)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = v[i];
      waitCyc(3);
      serClk = 1'b1;
      waitCyc(3);
      serClk = 1'b0;
    end
    waitCyc(3);
  endtask

  task automatic raiseLatch(input int addr, input logic [19:0] pay);
    qAddr.push_back(addr);
    qData.push_back(pay);
    serLatch = 1'b1;
    waitCyc(8);
  endtask

  task automatic dropLatch();
    serLatch = 1'b0;
    waitCyc(4);
  endtask

  task automatic writeReg(input int addr, input logic [19:0] pay);
    sendBits({10'd0, pay, addr[1:0]}, 22);
    raiseLatch(addr, pay);
    dropLatch();
  endtask

  task automatic checkAll(input string tag);
    @(negedge clk);
    checks++;
    if (ctrlRegs !== model || update !== 4'b0) begin
      errors++;
      $display("FAIL %s: regs=%h update=%b expected regs=%h update=0000",
               tag, ctrlRegs, update, model);
    end
  endtask

  // Monitor: compare each announced load against the queued expectation
  always @(negedge clk) begin
    if (rstN && update != 4'b0) begin
      checks++;
      if (qAddr.size() == 0) begin
        errors++;
        $display("FAIL R4: unexpected update=%b regs=%h expected no load", update, ctrlRegs);
      end else begin
        automatic int a = qAddr.pop_front();
        automatic logic [19:0] d = qData.pop_front();
        model[a] = d;
        if (update !== (4'b1 << a) || ctrlRegs !== model) begin
          errors++;
          $display("FAIL R2/R3/R5/R7: update=%b regs=%h expected update=%b regs=%h",
                   update, ctrlRegs, 4'b1 << a, model);
        end
      end
    end
  end

  initial begin
    waitCyc(200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    checkAll("R8 reset state");
    rstN = 1'b1;
    waitCyc(2);

    // R1 R2 R3: each index, distinct payload patterns
    writeReg(0, 20'hAAAAA);
    writeReg(1, 20'h80000);
    writeReg(2, 20'hFFFFF);
    writeReg(3, 20'h12345);
    checkAll("R1 R2 R3 after four writes");

    // R4: shift a frame without a latch edge
    sendBits({10'd0, 20'h0F0F0, 2'd1}, 22);
    waitCyc(10);
    checkAll("R4 shift without latch");

    // R4: latch held high, more bits shifted, no second load
    sendBits({10'd0, 20'h55555, 2'd2}, 22);
    raiseLatch(2, 20'h55555);
    sendBits({10'd0, 20'h00001, 2'd0}, 22);
    checkAll("R4 latch held high");
    dropLatch();
    raiseLatch(0, 20'h00001);
    dropLatch();
    checkAll("R4 next rise loads pending frame");

    // R6: 27 bits, junk leading bits discarded
    sendBits({5'b10111, 20'h6789A, 2'd3}, 27);
    raiseLatch(3, 20'h6789A);
    dropLatch();
    checkAll("R6 overlong burst");

    // R9: overwrite same index
    writeReg(1, 20'h00000);
    writeReg(1, 20'h3C3C3);
    checkAll("R9 overwrite");

    // R8: reset mid-run clears everything
    rstN = 1'b0;
    model = '0;
    waitCyc(2);
    checkAll("R8 reset after writes");
    rstN = 1'b1;
    waitCyc(4);

    checks++;
    if (qAddr.size() != 0) begin
      errors++;
      $display("FAIL R7: pending loads=%0d expected 0", qAddr.size());
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule